// File: doc/BRIEF.md
# SPI Memory Status Register Controller

This block is the slave-side command logic of a serial memory that owns the status register. The SPI clock, chip select, serial data input and write-protect pin are brought into the system clock domain. Bits are assembled MSB first on rising SPI clock edges. When chip select rises, the block acts on the frame it has seen. It handles three commands: write enable (0x06), status write (0x01) and status read (0x05).

A status write is committed only when the frame is exactly sixteen bits long. The write enable latch must be set, and the status register must not be locked by the write-protect pin. A committed write starts a self-timed cycle of `TW` system clocks. The busy flag is set for that cycle. The new protection values are applied only when the cycle finishes, and the write enable latch is cleared at the same moment. The status byte can be read at any time, including during the cycle. Its two block-protect bits are also driven to the address-protection logic outside this block.

Top module: `spi_status_ctrl`

## Requirements
- R1: After reset the status byte reads 0x00, `bp_o` is 00 and `miso_o` is 0.
- R2: A frame holding only the 8-bit opcode 0x06 (exactly 8 bits, then chip select rises) sets the write enable latch, which reads as status bit 1.
- R3: A status write (opcode 0x01) is rejected when the write enable latch is 0. A rejected write changes no status bit.
- R4: A status write is committed only if chip select rises after exactly 16 bits. A frame of 15 or 17 bits is discarded, and the write enable latch stays set.
- R5: When status bit 7 (write lock) is 1 and `wp_n_i` is low, status writes are discarded and the write enable latch stays set. With `wp_n_i` high, the write is committed.
- R6: A committed write sets the busy flag (status bit 0) for `TW` system clocks. During that time the status byte can be read and shows busy=1 with the write enable latch still set.
- R7: A write updates only bit 7 and bits 3:2 from the data byte. Bits 6:4 always read 0. Bits 1:0 keep their latch and busy meanings, whatever the data byte holds.
- R8: The lock bit and the block-protect bits, including `bp_o`, keep their old values while the cycle runs. They take the new values, and the write enable latch clears, when the cycle ends.
- R9: After opcode 0x05, the status byte is shifted out MSB first on `miso_o`, changing after falling SPI clock edges. It repeats for as long as chip select stays low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| sck_i | input | 1 | SPI clock from the master (mode 0) |
| csn_i | input | 1 | Chip select, active low |
| mosi_i | input | 1 | Serial data from the master |
| wp_n_i | input | 1 | Write-protect pin, active low |
| miso_o | output | 1 | Serial data to the master |
| bp_o | output | 2 | Block-protect bits for the address-protection logic |

## Verification
The assertions assume that the SPI clock and chip select each stay stable for several system clocks between edges. Under that assumption, synchronisation keeps their relative order, and a busy cycle can only start on a chip-select rise. The stimulus holds every SPI phase for eight system clocks. It changes inputs on falling system clock edges and samples `miso_o` just before each rising SPI clock edge. The write-protect pin is changed only while chip select is high.

// File: rtl/spi_sr_pkg.sv
package spi_sr_pkg;
    localparam logic [7:0] OP_WREN = 8'h06;
    localparam logic [7:0] OP_WRSR = 8'h01;
    localparam logic [7:0] OP_RDSR = 8'h05;
    localparam int BYTE_BITS = 8;
    localparam int CNT_W = 5;

    typedef struct packed {
        logic       lock;
        logic [1:0] bp;
    } prot_t;

    typedef struct packed {
        logic [CNT_W-1:0] nbits;
        logic [7:0]       op;
        logic [7:0]       data;
    } frame_t;

    function automatic logic [7:0] pack_status(prot_t p, logic wel, logic busy);
        return {p.lock, 3'b000, p.bp, wel, busy};
    endfunction

    function automatic prot_t take_write(logic [7:0] d);
        prot_t r;
        r.lock = d[7];
        r.bp   = d[3:2];
        return r;
    endfunction
endpackage

// File: rtl/spi_sr_sync.sv
module spi_sr_sync #(
    parameter int W = 4,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] meta;
    always_ff @(posedge clk) begin
        if (rst) begin
            meta <= RST_VAL;
            q    <= RST_VAL;
        end else begin
            meta <= d;
            q    <= meta;
        end
    end
endmodule

// File: rtl/spi_sr_frontend.sv
module spi_sr_frontend (
    input  logic clk,
    input  logic rst,
    input  logic sck_i,
    input  logic csn_i,
    input  logic mosi_i,
    input  logic wp_n_i,
    output logic sck_rise,
    output logic sck_fall,
    output logic cs_start,
    output logic cs_end,
    output logic cs_act,
    output logic mosi_s,
    output logic wp_n_s
);
    logic [3:0] raw, syn;
    logic sck_q, csn_q;

    assign raw = {sck_i, csn_i, mosi_i, wp_n_i};

    spi_sr_sync #(.W(4), .RST_VAL(4'b0101)) u_sync (
        .clk(clk), .rst(rst), .d(raw), .q(syn)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            sck_q <= 1'b0;
            csn_q <= 1'b1;
        end else begin
            sck_q <= syn[3];
            csn_q <= syn[2];
        end
    end

    assign sck_rise = syn[3] & ~sck_q;
    assign sck_fall = ~syn[3] & sck_q;
    assign cs_start = ~syn[2] & csn_q;
    assign cs_end   = syn[2] & ~csn_q;
    assign cs_act   = ~syn[2] & ~csn_q;
    assign mosi_s   = syn[1];
    assign wp_n_s   = syn[0];
endmodule

// File: rtl/spi_sr_shifter.sv
module spi_sr_shifter
    import spi_sr_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   cs_start,
    input  logic   cs_act,
    input  logic   sck_rise,
    input  logic   mosi_s,
    output frame_t frame,
    output logic   op_done
);
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};
    localparam logic [CNT_W-1:0] OP_LAST = CNT_W'(BYTE_BITS - 1);
    localparam logic [CNT_W-1:0] DT_LAST = CNT_W'(2 * BYTE_BITS - 1);

    logic [7:0] sreg;
    logic [7:0] nb;

    assign nb = {sreg[6:0], mosi_s};

    always_ff @(posedge clk) begin
        if (rst) begin
            sreg    <= '0;
            frame   <= '0;
            op_done <= 1'b0;
        end else begin
            op_done <= 1'b0;
            if (cs_start) begin
                sreg        <= '0;
                frame.nbits <= '0;
            end else if (cs_act && sck_rise) begin
                sreg <= nb;
                if (frame.nbits != CNT_MAX)
                    frame.nbits <= frame.nbits + 1'b1;
                if (frame.nbits == OP_LAST) begin
                    frame.op <= nb;
                    op_done  <= 1'b1;
                end
                if (frame.nbits == DT_LAST)
                    frame.data <= nb;
            end
        end
    end
endmodule

// File: rtl/spi_sr_core.sv
module spi_sr_core
    import spi_sr_pkg::*;
#(
    parameter int TW = 500,
    localparam int TW_W = (TW > 2) ? $clog2(TW) : 1
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            cs_end,
    input  frame_t          frame,
    input  logic            wp_n_s,
    output prot_t           prot,
    output logic            wel,
    output logic            busy,
    output logic [TW_W-1:0] timer
);
    localparam logic [CNT_W-1:0] WREN_LEN = CNT_W'(BYTE_BITS);
    localparam logic [CNT_W-1:0] WRSR_LEN = CNT_W'(2 * BYTE_BITS);

    prot_t pend;
    logic  hw_locked, do_wren, do_wrsr;

    assign hw_locked = prot.lock & ~wp_n_s;
    assign do_wren   = (frame.nbits == WREN_LEN) && (frame.op == OP_WREN);
    assign do_wrsr   = (frame.nbits == WRSR_LEN) && (frame.op == OP_WRSR)
                       && wel && !hw_locked;

    always_ff @(posedge clk) begin
        if (rst) begin
            prot  <= '0;
            pend  <= '0;
            wel   <= 1'b0;
            busy  <= 1'b0;
            timer <= '0;
        end else if (busy) begin
            if (timer == '0) begin
                busy <= 1'b0;
                wel  <= 1'b0;
                prot <= pend;
            end else begin
                timer <= timer - 1'b1;
            end
        end else if (cs_end) begin
            if (do_wren) begin
                wel <= 1'b1;
            end else if (do_wrsr) begin
                busy  <= 1'b1;
                timer <= TW_W'(TW - 1);
                pend  <= take_write(frame.data);
            end
        end
    end
endmodule

// File: rtl/spi_sr_readout.sv
module spi_sr_readout
    import spi_sr_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       cs_start,
    input  logic       cs_end,
    input  logic       cs_act,
    input  logic       op_done,
    input  logic [7:0] op,
    input  logic       sck_fall,
    input  logic [7:0] stat,
    output logic       miso
);
    logic       rd_on;
    logic [2:0] idx;
    logic [7:0] sh;

    always_ff @(posedge clk) begin
        if (rst || cs_start || cs_end) begin
            rd_on <= 1'b0;
            idx   <= '0;
            sh    <= '0;
            miso  <= 1'b0;
        end else begin
            if (op_done && op == OP_RDSR)
                rd_on <= 1'b1;
            if (rd_on && cs_act && sck_fall) begin
                idx <= idx + 1'b1;
                if (idx == '0) begin
                    miso <= stat[7];
                    sh   <= {stat[6:0], 1'b0};
                end else begin
                    miso <= sh[7];
                    sh   <= {sh[6:0], 1'b0};
                end
            end
        end
    end
endmodule

// File: rtl/spi_status_ctrl.sv
module spi_status_ctrl
    import spi_sr_pkg::*;
#(
    parameter int TW = 500
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       sck_i,
    input  logic       csn_i,
    input  logic       mosi_i,
    input  logic       wp_n_i,
    output logic       miso_o,
    output logic [1:0] bp_o
);
    localparam int TW_W = (TW > 2) ? $clog2(TW) : 1;

    logic sck_rise, sck_fall, cs_start, cs_end, cs_act, mosi_s, wp_n_s;
    logic op_done, wel, busy;
    logic [TW_W-1:0] timer;
    frame_t frame;
    prot_t  prot;
    logic [7:0] stat;

    spi_sr_frontend u_fe (
        .clk(clk), .rst(rst), .sck_i(sck_i), .csn_i(csn_i), .mosi_i(mosi_i),
        .wp_n_i(wp_n_i), .sck_rise(sck_rise), .sck_fall(sck_fall),
        .cs_start(cs_start), .cs_end(cs_end), .cs_act(cs_act),
        .mosi_s(mosi_s), .wp_n_s(wp_n_s)
    );

    spi_sr_shifter u_sh (
        .clk(clk), .rst(rst), .cs_start(cs_start), .cs_act(cs_act),
        .sck_rise(sck_rise), .mosi_s(mosi_s), .frame(frame), .op_done(op_done)
    );

    spi_sr_core #(.TW(TW)) u_core (
        .clk(clk), .rst(rst), .cs_end(cs_end), .frame(frame), .wp_n_s(wp_n_s),
        .prot(prot), .wel(wel), .busy(busy), .timer(timer)
    );

    assign stat = pack_status(prot, wel, busy);
    assign bp_o = prot.bp;

    spi_sr_readout u_rd (
        .clk(clk), .rst(rst), .cs_start(cs_start), .cs_end(cs_end),
        .cs_act(cs_act), .op_done(op_done), .op(frame.op),
        .sck_fall(sck_fall), .stat(stat), .miso(miso_o)
    );
endmodule

// File: rtl/spi_sr_checker.sv
module spi_sr_checker #(
    parameter int TW = 500,
    localparam int TW_W = (TW > 2) ? $clog2(TW) : 1
) (
    input logic            clk,
    input logic            rst,
    input logic            busy,
    input logic            wel,
    input logic            lock,
    input logic            wp_n_s,
    input logic            cs_end,
    input logic            cs_act,
    input logic            miso_o,
    input logic [1:0]      bp_o,
    input logic [TW_W-1:0] timer
);
    AST_BP_FROZEN_BUSY: assert property (@(posedge clk) disable iff (rst)
        (busy && $past(busy)) |-> $stable(bp_o)); // R8
    AST_BP_MOVES_AT_END: assert property (@(posedge clk) disable iff (rst)
        !$stable(bp_o) |-> $fell(busy)); // R8
    AST_WEL_CLEAR_AT_END: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> !wel); // R8
    AST_START_NEEDS_WEL: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> $past(wel)); // R3
    AST_START_ON_CS_RISE: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> $past(cs_end)); // R4
    AST_NO_START_LOCKED: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> !($past(lock) && !$past(wp_n_s))); // R5
    AST_TIMER_BOUND: assert property (@(posedge clk) disable iff (rst)
        busy |-> (int'(timer) < TW)); // R6
    AST_MISO_QUIET_IDLE: assert property (@(posedge clk) disable iff (rst)
        (!cs_act && !$past(cs_act)) |-> !miso_o); // R9
endmodule

bind spi_status_ctrl spi_sr_checker #(.TW(TW)) u_chk (
    .clk(clk), .rst(rst), .busy(busy), .wel(wel), .lock(prot.lock),
    .wp_n_s(wp_n_s), .cs_end(cs_end), .cs_act(cs_act), .miso_o(miso_o),
    .bp_o(bp_o), .timer(timer)
);

// File: tb/spi_status_ctrl_tb.sv
module spi_status_ctrl_tb;
    localparam int CLK_PERIOD = 10;
    localparam int HALF = 8;
    localparam int TW = 1000;
    localparam int NVEC = 8;

    // {wren first, frame bits, data, wp_n, pad, expected status}
    localparam logic [23:0] VEC [NVEC] = '{
        {1'b1, 5'd16, 8'hFF, 1'b1, 1'b0, 8'h8C},
        {1'b1, 5'd16, 8'h00, 1'b0, 1'b0, 8'h8E},
        {1'b0, 5'd16, 8'h04, 1'b1, 1'b0, 8'h04},
        {1'b0, 5'd16, 8'h08, 1'b1, 1'b0, 8'h04},
        {1'b1, 5'd15, 8'h08, 1'b1, 1'b0, 8'h06},
        {1'b0, 5'd17, 8'h08, 1'b1, 1'b0, 8'h06},
        {1'b0, 5'd16, 8'h88, 1'b0, 1'b0, 8'h88},
        {1'b1, 5'd16, 8'h00, 1'b1, 1'b0, 8'h00}
    };

    logic clk = 1'b0, rst = 1'b1;
    logic sck = 1'b0, csn = 1'b1, mosi = 1'b0, wp_n = 1'b1;
    logic miso;
    logic [1:0] bp;
    int checks = 0, errors = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    spi_status_ctrl #(.TW(TW)) u_dut (
        .clk(clk), .rst(rst), .sck_i(sck), .csn_i(csn), .mosi_i(mosi),
        .wp_n_i(wp_n), .miso_o(miso), .bp_o(bp)
    );

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic frame(input logic [23:0] word, input int n, output logic [23:0] rx);
        rx = '0;
        csn = 1'b0;
        wait_clk(HALF);
        for (int i = 0; i < n; i++) begin
            mosi = word[23 - i];
            wait_clk(HALF);
            rx = {rx[22:0], miso};
            sck = 1'b1;
            wait_clk(HALF);
            sck = 1'b0;
        end
        wait_clk(HALF);
        csn = 1'b1;
        mosi = 1'b0;
        wait_clk(2 * HALF);
    endtask

    task automatic read_stat(output logic [7:0] b0, output logic [7:0] b1);
        logic [23:0] rx;
        frame({8'h05, 16'h0000}, 24, rx);
        b0 = rx[15:8];
        b1 = rx[7:0];
    endtask

    task automatic wren();
        logic [23:0] rx;
        frame({8'h06, 16'h0000}, 8, rx);
    endtask

    task automatic wrsr(input logic [7:0] d, input int n);
        logic [23:0] rx;
        frame({8'h01, d, 8'h00}, n, rx);
    endtask

    initial begin
        logic [7:0] a, b;
        wait_clk(6);
        rst = 1'b0;
        wait_clk(4);

        // R1: reset state
        chk("R1 miso", {7'd0, miso}, 8'h00);
        chk("R1 bp", {6'd0, bp}, 8'h00);
        read_stat(a, b);
        chk("R1 status", a, 8'h00);

        // R2: write enable sets latch
        wren();
        read_stat(a, b);
        chk("R2 wel set", a, 8'h02);

        // R6/R8: busy readable, old bits held during cycle
        wrsr(8'h0C, 16);
        wait_clk(20);
        read_stat(a, b);
        chk("R6 busy status", a, 8'h03);
        chk("R9 repeat byte", b, 8'h03);
        chk("R8 bp held", {6'd0, bp}, 8'h00);
        wait_clk(TW);
        read_stat(a, b);
        chk("R8 new bits applied, wel clear", a, 8'h0C);
        chk("R8 bp updated", {6'd0, bp}, 8'h0C >> 2);

        // Table walk: R3 R4 R5 R7
        for (int v = 0; v < NVEC; v++) begin
            logic [23:0] e;
            e = VEC[v];
            wp_n = e[9];
            wait_clk(4);
            if (e[23]) wren();
            wrsr(e[17:10], int'(e[22:18]));
            wait_clk(TW + 100);
            read_stat(a, b);
            chk($sformatf("R3/R4/R5/R7 vector %0d", v), a, e[7:0]);
            chk($sformatf("R7 bp vector %0d", v), {6'd0, bp}, {6'd0, e[3:2]});
        end
        wp_n = 1'b1;

        // R9: repeated byte during read after setting a distinct value
        wren();
        wrsr(8'hB4, 16);
        wait_clk(TW + 100);
        read_stat(a, b);
        chk("R9 first byte", a, 8'h84);
        chk("R9 second byte", b, 8'h84);
        chk("R9 miso idle", {7'd0, miso}, 8'h00);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule